// File: doc/BRIEF.md
# Interrupt Routing Register File

This block sits in a PCI host bridge and decides which interrupt inputs reach the vector lines. Thirty-two slot interrupt inputs are grouped four to a mapping register, so eight registers cover them. Sixteen on-board device inputs each have a register of their own, taken from a bank of thirty-two. Each mapping register holds a fixed 11-bit interrupt number in its low bits, which writes cannot change, and writable control bits above it. Bit 31 is the enable.

Each of the 48 vector outputs is a registered line that reacts to events. When its input changes level, the line takes the new level if the mapping entry is enabled, and goes low if it is not. Between input changes the line holds its value. Software can also drop a single line through two write-only clear windows, one for slot lines and one for on-board lines. A clear leaves the mapping registers untouched.

The register port is 32 bits wide, with a byte address, a write strobe and combinational read data. Registers are spaced 8 bytes apart. Only the word with address bit 2 set is live.

Top module: `irqmap_router`

## Requirements
- R1: After reset every vector output is 0 and every mapping register reads back as its interrupt number with bit 31 clear. Slot register i holds 0x7C0 | (i<<2) and on-board register i holds 0x7E0 + i.
- R2: A write to a mapping register leaves bits 10:0 unchanged and loads bits 31:11 from the write data.
- R3: An address with bit 2 clear reads 0, and writes to it change no register.
- R4: Slot mapping registers occupy 0x0C00–0x0C3F, indexed by address bits 5:3. Slot input n (0..31) drives vector n and is gated by bit 31 of slot register n>>2.
- R5: On-board mapping registers are reached at 0x1000–0x1080, indexed by address bits 7:3. On-board input k (0..15) drives vector 32+k and is gated by bit 31 of on-board register k. Address 0x1084 and above read 0.
- R6: When an input changes level and its entry is enabled, the vector takes the new input level at the next clock edge.
- R7: When an input changes level and its entry is disabled, the vector is 0 after the next clock edge.
- R8: Without an input change, a vector holds its value. This is true when its entry is enabled or disabled, and after a clear while the input stays high.
- R9: A write to 0x1400–0x143F with bit 2 set drives vector (addr>>3)&7 to 0 at that clock edge and changes no mapping register.
- R10: A write to 0x1800–0x1860 with bit 2 set drives vector 32 + ((addr>>3)&31) to 0 at that clock edge and changes no mapping register.
- R11: If a clear and an input change for the same vector fall on the same clock edge, the clear wins and the vector becomes 0.
- R12: Addresses outside the four windows read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, acts at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_in | input | 48 | Level interrupt inputs: 0..31 slot, 32..47 on-board |
| ivec_out | output | 48 | Registered interrupt vector lines |

## Verification
The bench targets the event-driven nature of the outputs. It enables an entry while its input is already high, disables an entry while its vector is high, and holds an input high after a clear. A design that followed levels instead of changes would raise or drop the vector in each of these cases. It also makes sure one slot enable gates exactly four neighbouring lines and that on-board entries reach vectors 32 and up. A decoder that is off by one in its index or its window edges would route, clear or read the wrong line or register. A clear that lands on the same edge as a rising input must leave the line low. Writes to the low word and to an unmapped offset must leave every register as it was, which catches a decoder that ignores bit 2 or that decodes too widely.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 5;
    localparam int EN_BIT   = 31;

    localparam logic [DATA_W-1:0] PROT_MASK = 32'h0000_07FF;

    localparam logic [ADDR_W-1:0] PCI_MAP_LO  = 16'h0C00;
    localparam logic [ADDR_W-1:0] PCI_MAP_HI  = 16'h0C3F;
    localparam logic [ADDR_W-1:0] OBIO_MAP_LO = 16'h1000;
    localparam logic [ADDR_W-1:0] OBIO_MAP_HI = 16'h1080;
    localparam logic [ADDR_W-1:0] PCI_CLR_LO  = 16'h1400;
    localparam logic [ADDR_W-1:0] PCI_CLR_HI  = 16'h143F;
    localparam logic [ADDR_W-1:0] OBIO_CLR_LO = 16'h1800;
    localparam logic [ADDR_W-1:0] OBIO_CLR_HI = 16'h1860;

    typedef struct packed {
        logic             pci_map;
        logic             obio_map;
        logic             pci_clr;
        logic             obio_clr;
        logic             upper;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [DATA_W-1:0] pci_rst_val(input int i);
        return DATA_W'((32'h1F << 6) | (i << 2));
    endfunction

    function automatic logic [DATA_W-1:0] obio_rst_val(input int i);
        return DATA_W'(((32'h1F << 6) | 32'h20) + i);
    endfunction

    function automatic logic [DATA_W-1:0] merge_wr(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] wd);
        return (cur & PROT_MASK) | (wd & ~PROT_MASK);
    endfunction

endpackage

// File: rtl/irqmap_decode.sv
module irqmap_decode
    import irqmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec          = '0;
        dec.upper    = addr[2];
        dec.idx      = addr[7:3];
        dec.pci_map  = (addr >= PCI_MAP_LO)  && (addr <= PCI_MAP_HI);
        dec.obio_map = (addr >= OBIO_MAP_LO) && (addr <= OBIO_MAP_HI);
        dec.pci_clr  = (addr >= PCI_CLR_LO)  && (addr <= PCI_CLR_HI);
        dec.obio_clr = (addr >= OBIO_CLR_LO) && (addr <= OBIO_CLR_HI);
    end

endmodule

// File: rtl/irqmap_regs.sv
module irqmap_regs
    import irqmap_pkg::*;
#(
    parameter int N_PCI_MAP     = 8,
    parameter int N_OBIO_MAP    = 32,
    parameter int LINES_PER_MAP = 4,
    parameter int N_OBIO_SRC    = 16,
    localparam int N_PCI_LINES  = N_PCI_MAP * LINES_PER_MAP,
    localparam int NUM_VEC      = N_PCI_LINES + N_OBIO_SRC,
    localparam int PIDX_W       = $clog2(N_PCI_MAP)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  dec_t               dec,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_VEC-1:0] line_en
);

    typedef struct packed {
        logic [N_PCI_MAP-1:0][DATA_W-1:0]  pci;
        logic [N_OBIO_MAP-1:0][DATA_W-1:0] obio;
    } regs_t;

    regs_t             st_d, st_q;
    logic [PIDX_W-1:0] pidx;
    logic [IDX_W-1:0]  oidx;

    assign pidx = dec.idx[PIDX_W-1:0];
    assign oidx = dec.idx;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (dec.upper) begin
            if (dec.pci_map && (int'(dec.idx) < N_PCI_MAP)) begin
                rdata = st_q.pci[pidx];
                if (we) begin
                    st_d.pci[pidx] = merge_wr(st_q.pci[pidx], wdata);
                end
            end else if (dec.obio_map && (int'(oidx) < N_OBIO_MAP)) begin
                rdata = st_q.obio[oidx];
                if (we) begin
                    st_d.obio[oidx] = merge_wr(st_q.obio[oidx], wdata);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PCI_MAP; i++) begin
                st_q.pci[i] <= pci_rst_val(i);
            end
            for (int i = 0; i < N_OBIO_MAP; i++) begin
                st_q.obio[i] <= obio_rst_val(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Slot lines share one entry per group, on-board lines own one each.
    for (genvar n = 0; n < NUM_VEC; n++) begin : g_en
        if (n < N_PCI_LINES) begin : g_pci
            assign line_en[n] = st_q.pci[n / LINES_PER_MAP][EN_BIT];
        end else begin : g_obio
            assign line_en[n] = st_q.obio[n - N_PCI_LINES][EN_BIT];
        end
    end

endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate #(
    parameter int NUM_VEC = 48,
    localparam int LINE_W = $clog2(NUM_VEC)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic [NUM_VEC-1:0] line_en,
    input  logic               clr_valid,
    input  logic [LINE_W-1:0]  clr_line,
    output logic [NUM_VEC-1:0] ivec_out
);

    typedef struct packed {
        logic [NUM_VEC-1:0] prev;
        logic [NUM_VEC-1:0] out;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        for (int n = 0; n < NUM_VEC; n++) begin
            if (clr_valid && (clr_line == LINE_W'(n))) begin
                st_d.out[n] = 1'b0;
            end else if (irq_in[n] != st_q.prev[n]) begin
                st_d.out[n] = line_en[n] & irq_in[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ivec_out = st_q.out;

endmodule

// File: rtl/irqmap_router.sv
module irqmap_router
    import irqmap_pkg::*;
#(
    parameter int N_PCI_MAP     = 8,
    parameter int N_OBIO_MAP    = 32,
    parameter int LINES_PER_MAP = 4,
    parameter int N_OBIO_SRC    = 16,
    localparam int N_PCI_LINES  = N_PCI_MAP * LINES_PER_MAP,
    localparam int NUM_VEC      = N_PCI_LINES + N_OBIO_SRC,
    localparam int LINE_W       = $clog2(NUM_VEC)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_VEC-1:0] irq_in,
    output logic [NUM_VEC-1:0] ivec_out
);

    dec_t               dec;
    logic [NUM_VEC-1:0] line_en;
    logic               clr_valid;
    logic [LINE_W-1:0]  clr_line;

    irqmap_decode u_dec (
        .addr (reg_addr),
        .dec  (dec)
    );

    irqmap_regs #(
        .N_PCI_MAP     (N_PCI_MAP),
        .N_OBIO_MAP    (N_OBIO_MAP),
        .LINES_PER_MAP (LINES_PER_MAP),
        .N_OBIO_SRC    (N_OBIO_SRC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .line_en (line_en)
    );

    // Clear target: slot window uses the raw 3-bit index,
    // on-board window offsets by the slot line count.
    always_comb begin
        clr_valid = 1'b0;
        clr_line  = '0;
        if (reg_we && dec.upper) begin
            if (dec.pci_clr) begin
                clr_valid = 1'b1;
                clr_line  = LINE_W'(dec.idx[2:0]);
            end else if (dec.obio_clr) begin
                clr_valid = 1'b1;
                clr_line  = LINE_W'(N_PCI_LINES + int'(dec.idx));
            end
        end
    end

    irqmap_gate #(
        .NUM_VEC (NUM_VEC)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .line_en   (line_en),
        .clr_valid (clr_valid),
        .clr_line  (clr_line),
        .ivec_out  (ivec_out)
    );

endmodule

// File: rtl/irqmap_router_chk.sv
module irqmap_router_chk #(
    parameter int NUM_VEC   = 48,
    parameter int N_PCI_MAP = 8
)(
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        reg_addr,
    input logic               reg_we,
    input logic [31:0]        reg_rdata,
    input logic [NUM_VEC-1:0] irq_in,
    input logic [NUM_VEC-1:0] ivec_out
);

    AST_LOWER_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_addr[2]) |-> (reg_rdata == 32'h0));  // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[15:12] == 4'h2) |-> (reg_rdata == 32'h0));  // R12

    for (genvar i = 0; i < N_PCI_MAP; i++) begin : g_pci
        AST_NUMBER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == 16'(32'h0C04 + 8 * i)) |->
            (reg_rdata[10:0] == 11'(32'h7C0 | (i * 4))));  // R2

        AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && (reg_addr == 16'(32'h1404 + 8 * i))) |=> !ivec_out[i]);  // R9
    end

    for (genvar n = 0; n < NUM_VEC; n++) begin : g_line
        AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ivec_out[n]) |-> $past(irq_in[n]));  // R6
    end

endmodule

bind irqmap_router irqmap_router_chk #(
    .NUM_VEC   (NUM_VEC),
    .N_PCI_MAP (N_PCI_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .irq_in    (irq_in),
    .ivec_out  (ivec_out)
);

// File: tb/irqmap_router_test.sv
`timescale 1ns/1ps
module irqmap_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [47:0] irq_in = '0;
    logic [47:0] ivec_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqmap_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .ivec_out  (ivec_out)
    );

    // op 0: write then compare outputs, 1: read compare, 2: drive inputs, clock, compare outputs
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [47:0] val;
        logic [47:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 16'h0C04, 48'h0, 48'h0000_0000_07C0, 4'd1},   // R1
        '{2'd1, 16'h0C3C, 48'h0, 48'h0000_0000_07DC, 4'd4},   // R4
        '{2'd1, 16'h1004, 48'h0, 48'h0000_0000_07E0, 4'd1},   // R1
        '{2'd1, 16'h107C, 48'h0, 48'h0000_0000_07EF, 4'd5},   // R5
        '{2'd1, 16'h0C00, 48'h0, 48'h0,              4'd3},   // R3
        '{2'd0, 16'h0C0C, 48'hFFFF_FFFF, 48'h0,      4'd2},   // R2
        '{2'd1, 16'h0C0C, 48'h0, 48'h0000_FFFF_FFC4, 4'd2},   // R2
        '{2'd0, 16'h0C0C, 48'h8000_0000, 48'h0,      4'd2},   // R2
        '{2'd1, 16'h0C0C, 48'h0, 48'h0000_8000_07C4, 4'd2},   // R2
        '{2'd2, 16'h0,    48'h0000_0000_00F0, 48'h0000_0000_00F0, 4'd6},  // R6
        '{2'd2, 16'h0,    48'h0000_0000_00FF, 48'h0000_0000_00F0, 4'd7},  // R7
        '{2'd0, 16'h1014, 48'h8000_0000, 48'h0000_0000_00F0, 4'd5},       // R5
        '{2'd2, 16'h0,    48'h0004_0000_00FF, 48'h0004_0000_00F0, 4'd5},  // R5
        '{2'd2, 16'h0,    48'h000C_0000_00FF, 48'h0004_0000_00F0, 4'd7},  // R7
        '{2'd0, 16'h142C, 48'h0, 48'h0004_0000_00D0, 4'd9},               // R9
        '{2'd1, 16'h0C0C, 48'h0, 48'h0000_8000_07C4, 4'd9},               // R9
        '{2'd2, 16'h0,    48'h000C_0000_00FF, 48'h0004_0000_00D0, 4'd8},  // R8
        '{2'd0, 16'h1814, 48'h0, 48'h0000_0000_00D0, 4'd10},              // R10
        '{2'd1, 16'h1014, 48'h0, 48'h0000_8000_07E2, 4'd10},              // R10
        '{2'd0, 16'h0C04, 48'h8000_0000, 48'h0000_0000_00D0, 4'd8},       // R8
        '{2'd0, 16'h0C0C, 48'h0, 48'h0000_0000_00D0, 4'd8},               // R8
        '{2'd2, 16'h0,    48'h000C_0000_00FE, 48'h0000_0000_00D0, 4'd6},  // R6
        '{2'd2, 16'h0,    48'h000C_0000_00FF, 48'h0000_0000_00D1, 4'd6},  // R6
        '{2'd2, 16'h0,    48'h000C_0000_000F, 48'h0000_0000_0001, 4'd7},  // R7
        '{2'd0, 16'h0C08, 48'hFFFF_FFFF, 48'h0000_0000_0001, 4'd3},       // R3
        '{2'd1, 16'h0C0C, 48'h0, 48'h0000_0000_07C4, 4'd3},               // R3
        '{2'd0, 16'h2004, 48'hFFFF_FFFF, 48'h0000_0000_0001, 4'd12},      // R12
        '{2'd1, 16'h2004, 48'h0, 48'h0,              4'd12},              // R12
        '{2'd1, 16'h1084, 48'h0, 48'h0,              4'd5},               // R5
        '{2'd0, 16'h107C, 48'h8000_0000, 48'h0000_0000_0001, 4'd5},       // R5
        '{2'd2, 16'h0,    48'h800C_0000_000F, 48'h8000_0000_0001, 4'd5}   // R5
    };

    task automatic check(input int req, input logic [47:0] act, input logic [47:0] exp,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 48'(reg_rdata), 48'(exp), "read");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, ivec_out, 48'h0, "outputs after reset");  // R1

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                2'd0: begin
                    wr(TBL[i].addr, TBL[i].val[31:0]);
                    check(int'(TBL[i].req), ivec_out, TBL[i].exp, "outputs after write");
                end
                2'd1: rd_check(int'(TBL[i].req), TBL[i].addr, TBL[i].exp[31:0]);
                default: begin
                    @(negedge clk);
                    irq_in = TBL[i].val;
                    @(negedge clk);
                    check(int'(TBL[i].req), ivec_out, TBL[i].exp, "outputs after input");
                end
            endcase
        end

        // R11: clear and rising input on the same edge, entry enabled
        wr(16'h0C0C, 32'h8000_0000);
        @(negedge clk);
        irq_in    = 48'h800C_0000_001F;
        reg_addr  = 16'h1424;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        check(11, ivec_out, 48'h8000_0000_0001, "clear beats input change");  // R11
        @(negedge clk);
        check(8, ivec_out, 48'h8000_0000_0001, "steady input after clear");   // R8

        // R6: the same line rises normally without a clear
        @(negedge clk);
        irq_in = 48'h800C_0000_000F;
        @(negedge clk);
        irq_in = 48'h800C_0000_001F;
        @(negedge clk);
        check(6, ivec_out, 48'h8000_0000_0011, "enabled rise");  // R6

        // R1: reset in mid-run restores the registers and drops all lines
        @(negedge clk);
        irq_in = '0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        @(negedge clk);
        check(1, ivec_out, 48'h0, "outputs after second reset");
        rd_check(1, 16'h0C0C, 32'h0000_07C4);
        rd_check(1, 16'h107C, 32'h0000_07EF);
        rd_check(1, 16'h1014, 32'h0000_07E2);

        finish_run();
    end

endmodule